// File: doc/BRIEF.md
# Accumulator Stored-Program CPU Core

A compact multi-cycle processor built around one 16-bit accumulator. It holds programs and data together in a word-addressed memory inside the block. It fetches one instruction, decodes it, runs it to completion and then starts the next fetch. All memory traffic moves through a 12-bit address latch and a 16-bit data latch. Byte-wide input and output use valid/ready handshakes. Arithmetic is two's complement and wraps on 16 bits.

An instruction word carries a 4-bit opcode in bits [15:12] and a 12-bit direct operand address in bits [11:0]. While reset is held low, the memory is filled through a write-only load port. When reset is released, execution starts at address 0 with the accumulator cleared. The program counter is 12 bits wide. Memory depth is 2^MEM_AW words, and addresses are reduced to their low MEM_AW bits.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, halted_o, out_valid_o and in_ready_o are 0. After reset is released, execution begins at address 0 with AC = 0.
- R2: Opcode 1 loads AC from M[addr]. Opcode 6 presents AC[7:0] on out_data_o with out_valid_o high, and the transfer completes on a clock edge where out_ready_i is high.
- R3: Opcode 3 sets AC = AC + M[addr] and opcode 4 sets AC = AC - M[addr], both modulo 2^16 with no trap.
- R4: Opcode 2 writes AC into M[addr], so a later load from that address returns it.
- R5: Opcode 5 holds in_ready_o high until in_valid_i is seen. It then writes in_data_i into AC[7:0] and leaves AC[15:8] unchanged, and AC does not change while it waits.
- R6: Opcode 7 raises halted_o. The core then stops: no further output transfers and no input requests until reset.
- R7: Opcode 8 skips the next instruction when the test in IR[11:10] holds: 00 means AC < 0, 01 means AC == 0, 10 means AC > 0 (signed). Code 11 never skips.
- R8: Opcode 9 sets PC to IR[11:0].
- R9: Opcodes 0 and 10 through 15 change neither AC nor memory, and execution continues at the next word.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; the load port works only while it is low |
| load_we_i | input | 1 | Memory load write enable (effective during reset) |
| load_addr_i | input | MEM_AW | Memory load word address |
| load_data_i | input | 16 | Memory load word |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte available |
| in_ready_o | output | 1 | Core waiting for an input byte |
| out_data_o | output | 8 | Output byte register |
| out_valid_o | output | 1 | Output byte offered |
| out_ready_i | input | 1 | Consumer accepts output byte |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The bench builds the core with MEM_AW = 8. This gives 256 words of storage, so a full memory reload costs only 256 cycles, and many short random programs fit in the cycle budget. Operands and code sit at addresses below 0x100, so every opcode, the skip codes, the jump target and the store-then-reload path are reached with 12-bit address fields that fit the smaller array. Random handshake stalls on both byte ports drive the stalled-output and input-wait paths on each run.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = 4;
  localparam int IO_W   = 8;

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd4;
  localparam logic [OP_W-1:0] OP_IN    = 4'd5;
  localparam logic [OP_W-1:0] OP_OUT   = 4'd6;
  localparam logic [OP_W-1:0] OP_HALT  = 4'd7;
  localparam logic [OP_W-1:0] OP_SKIP  = 4'd8;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd9;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_DEC, S_RD, S_EXE, S_WR,
    S_IN, S_IN2, S_OUT1, S_OUT2, S_HALT
  } state_t;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] y_o
);
  // modulo 2^DW, carry discarded
  assign y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/acc_cpu_skip.sv
module acc_cpu_skip #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] ac_i,
  input  logic [1:0]    code_i,
  output logic          take_o
);
  logic neg, zero;
  assign neg  = ac_i[DW-1];
  assign zero = (ac_i == '0);

  always_comb begin
    unique case (code_i)
      2'b00:   take_o = neg;
      2'b01:   take_o = zero;
      2'b10:   take_o = !neg && !zero;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [IO_W-1:0]   in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [IO_W-1:0]   out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              halted_o
);
  state_t              st_q;
  logic [WORD_W-1:0]   ac_q, mbr_q, ir_q;
  logic [ADDR_W-1:0]   pc_q, mar_q;
  logic [IO_W-1:0]     in_reg_q, out_reg_q;

  logic [OP_W-1:0]     opc;
  logic [ADDR_W-1:0]   opnd;
  logic                mem_we;
  logic [MEM_AW-1:0]   mem_waddr;
  logic [WORD_W-1:0]   mem_wdata, mem_rdata, alu_y;
  logic                skip_take;

  assign opc  = ir_q[WORD_W-1 -: OP_W];
  assign opnd = ir_q[ADDR_W-1:0];

  // load port owns the memory only while the core is held in reset
  assign mem_we    = rst_ni ? (st_q == S_WR) : load_we_i;
  assign mem_waddr = rst_ni ? mar_q[MEM_AW-1:0] : load_addr_i;
  assign mem_wdata = rst_ni ? mbr_q : load_data_i;

  acc_cpu_mem #(.AW(MEM_AW), .DW(WORD_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mar_q[MEM_AW-1:0]),
    .rdata_o (mem_rdata)
  );

  acc_cpu_alu #(.DW(WORD_W)) u_alu (
    .a_i   (ac_q),
    .b_i   (mbr_q),
    .sub_i (opc == OP_SUB),
    .y_o   (alu_y)
  );

  acc_cpu_skip #(.DW(WORD_W)) u_skip (
    .ac_i   (ac_q),
    .code_i (ir_q[ADDR_W-1 -: 2]),
    .take_o (skip_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_F1;
      ac_q      <= '0;
      mbr_q     <= '0;
      ir_q      <= '0;
      pc_q      <= '0;
      mar_q     <= '0;
      in_reg_q  <= '0;
      out_reg_q <= '0;
    end else begin
      unique case (st_q)
        S_F1: begin
          mar_q <= pc_q;
          st_q  <= S_F2;
        end
        S_F2: begin
          mbr_q <= mem_rdata;
          pc_q  <= pc_q + ADDR_ONE;
          st_q  <= S_F3;
        end
        S_F3: begin
          ir_q <= mbr_q;
          st_q <= S_DEC;
        end
        S_DEC: begin
          st_q <= S_F1;
          case (opc)
            OP_LOAD, OP_ADD, OP_SUB: begin
              mar_q <= opnd;
              st_q  <= S_RD;
            end
            OP_STORE: begin
              mar_q <= opnd;
              mbr_q <= ac_q;
              st_q  <= S_WR;
            end
            OP_IN:   st_q <= S_IN;
            OP_OUT:  st_q <= S_OUT1;
            OP_HALT: st_q <= S_HALT;
            OP_SKIP: if (skip_take) pc_q <= pc_q + ADDR_ONE;
            OP_JUMP: pc_q <= opnd;
            default: ;
          endcase
        end
        S_RD: begin
          mbr_q <= mem_rdata;
          st_q  <= S_EXE;
        end
        S_EXE: begin
          ac_q <= (opc == OP_LOAD) ? mbr_q : alu_y;
          st_q <= S_F1;
        end
        S_WR: st_q <= S_F1;
        S_IN: begin
          if (in_valid_i) begin
            in_reg_q <= in_data_i;
            st_q     <= S_IN2;
          end
        end
        S_IN2: begin
          ac_q[IO_W-1:0] <= in_reg_q;
          st_q           <= S_F1;
        end
        S_OUT1: begin
          out_reg_q <= ac_q[IO_W-1:0];
          st_q      <= S_OUT2;
        end
        S_OUT2: if (out_ready_i) st_q <= S_F1;
        S_HALT: st_q <= S_HALT;
        default: st_q <= S_F1;
      endcase
    end
  end

  assign in_ready_o  = (st_q == S_IN);
  assign out_valid_o = (st_q == S_OUT2);
  assign out_data_o  = out_reg_q;
  assign halted_o    = (st_q == S_HALT);

  // R6: halt is terminal
  p_halt_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_q) && $stable(ac_q));

  // R10: offered byte held under backpressure
  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R5: accumulator untouched while waiting for input
  p_in_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> $stable(ac_q));

  // R4: memory write carries the accumulator
  p_store_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> mbr_q == ac_q);

  // R8: jump target taken from the operand field
  p_jump_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DEC && opc == OP_JUMP) |=> pc_q == $past(opnd));

  // R9: unassigned opcodes leave AC alone and fall through
  p_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DEC && (opc == 4'd0 || opc > OP_JUMP)) |=>
      $stable(ac_q) && $stable(pc_q) && st_q == S_F1);
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_we_i = 1'b0;
  logic [AW-1:0] load_addr_i = '0;
  logic [15:0]   load_data_i = '0;
  logic [7:0]    in_data_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [7:0]    out_data_o;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic          halted_o;

  always #10 clk_i = ~clk_i;

  acc_cpu #(.MEM_AW(AW)) uut (
    .clk_i, .rst_ni, .load_we_i, .load_addr_i, .load_data_i,
    .in_data_i, .in_valid_i, .in_ready_o,
    .out_data_o, .out_valid_o, .out_ready_i, .halted_o
  );

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;
  logic [15:0] prog [NW];
  logic [7:0]  exp_q[$];
  logic [7:0]  got_q[$];
  logic [7:0]  in_q[$];

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  endtask

  function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
    return {op, a};
  endfunction

  function automatic bit skip_ref(logic [15:0] v, logic [1:0] cc);
    case (cc)
      2'b00:   return v[15];
      2'b01:   return v == 16'h0;
      2'b10:   return !v[15] && v != 16'h0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < NW; i++) prog[i] = 16'h0;
    exp_q.delete();
    in_q.delete();
  endtask

  task automatic run(string req);
    int  cyc;
    bit  done, hold;
    logic [7:0] held;
    rst_ni = 1'b0; out_ready_i = 1'b0; in_valid_i = 1'b0;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk_i);
      load_we_i = 1'b1; load_addr_i = i[AW-1:0]; load_data_i = prog[i];
    end
    @(negedge clk_i);
    load_we_i = 1'b0;
    chk(!halted_o && !out_valid_o && !in_ready_o, "R1 reset outputs",
        {halted_o, out_valid_o, in_ready_o}, 0);
    rst_ni = 1'b1;
    got_q.delete();
    cyc = 0; done = 0; hold = 0; held = '0;
    while (!done && cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
      if (hold) begin
        chk(out_valid_o && out_data_o == held, "R10 stalled output held",
            {out_valid_o, out_data_o}, {1'b1, held});
        hold = 0;
      end
      out_ready_i = ($urandom_range(0, 2) != 0);
      in_valid_i  = (in_q.size() > 0) && ($urandom_range(0, 2) != 0);
      in_data_i   = (in_q.size() > 0) ? in_q[0] : 8'h0;
      #1;
      if (out_valid_o) begin
        if (out_ready_i) got_q.push_back(out_data_o);
        else begin hold = 1; held = out_data_o; end
      end
      if (in_ready_o && in_valid_i) void'(in_q.pop_front());
      if (halted_o) done = 1;
    end
    chk(done, {req, " R6 halt reached"}, done, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      out_ready_i = 1'b1;
      in_valid_i  = 1'b1;
      #1;
      chk(halted_o && !out_valid_o && !in_ready_o, "R6 stays halted",
          {halted_o, out_valid_o, in_ready_o}, 3'b100);
    end
    in_valid_i = 1'b0;
    chk(got_q.size() == exp_q.size(), {req, " output count"},
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
  endtask

  // R2 R3 R4 arithmetic, store, reload
  task automatic prog_arith(logic [15:0] a, logic [15:0] b, logic [15:0] c);
    logic [15:0] s1, s2;
    clear_prog();
    s1 = a + b; s2 = s1 - c;
    prog[0] = ins(4'd1, 12'h080); prog[1] = ins(4'd3, 12'h081);
    prog[2] = ins(4'd6, 12'h000); prog[3] = ins(4'd4, 12'h082);
    prog[4] = ins(4'd6, 12'h000); prog[5] = ins(4'd2, 12'h083);
    prog[6] = ins(4'd1, 12'h084); prog[7] = ins(4'd6, 12'h000);
    prog[8] = ins(4'd1, 12'h083); prog[9] = ins(4'd6, 12'h000);
    prog[10] = ins(4'd7, 12'h000); prog[11] = ins(4'd6, 12'h000);
    prog[8'h80] = a; prog[8'h81] = b; prog[8'h82] = c;
    prog[8'h83] = 16'h5555; prog[8'h84] = 16'h0000;
    exp_q.push_back(s1[7:0]); exp_q.push_back(s2[7:0]);
    exp_q.push_back(8'h00);   exp_q.push_back(s2[7:0]);
    run("R2 R3 R4 arith/store");
  endtask

  // R7 skip after a wrapped add
  task automatic prog_skip(logic [15:0] a, logic [15:0] b, logic [1:0] cc);
    logic [15:0] s;
    clear_prog();
    s = a + b;
    prog[0] = ins(4'd1, 12'h080); prog[1] = ins(4'd3, 12'h081);
    prog[2] = ins(4'd8, {cc, 10'h0}); prog[3] = ins(4'd1, 12'h082);
    prog[4] = ins(4'd6, 12'h000); prog[5] = ins(4'd7, 12'h000);
    prog[8'h80] = a; prog[8'h81] = b; prog[8'h82] = 16'h0011;
    exp_q.push_back(skip_ref(s, cc) ? s[7:0] : 8'h11);
    run("R7 R3 skip");
  endtask

  // R5 input, R9 unassigned opcodes, R8 jump
  task automatic prog_io(logic [7:0] hi, logic [7:0] d);
    clear_prog();
    prog[0] = ins(4'd1, 12'h080); prog[1] = ins(4'd5, 12'h000);
    prog[2] = 16'h0081; prog[3] = 16'hA082; prog[4] = 16'hF080;
    prog[5] = ins(4'd6, 12'h000); prog[6] = ins(4'd4, 12'h081);
    prog[7] = ins(4'd8, 12'h400); prog[8] = ins(4'd1, 12'h082);
    prog[9] = ins(4'd9, 12'h020); prog[10] = ins(4'd7, 12'h000);
    prog[8'h20] = ins(4'd6, 12'h000); prog[8'h21] = ins(4'd7, 12'h000);
    prog[8'h80] = {hi, 8'h5A}; prog[8'h81] = {hi, d}; prog[8'h82] = 16'h0011;
    in_q.push_back(d);
    exp_q.push_back(d); exp_q.push_back(8'h00);
    run("R5 R8 R9 input/jump/nop");
    chk(in_q.size() == 0, "R5 input consumed", in_q.size(), 0);
  endtask

  // R1 accumulator cleared by reset
  task automatic prog_reset_ac();
    clear_prog();
    prog[0] = ins(4'd6, 12'h000); prog[1] = ins(4'd7, 12'h000);
    exp_q.push_back(8'h00);
    run("R1 AC cleared");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    prog_arith(16'hFFFF, 16'h0001, 16'h0002);
    prog_reset_ac();
    for (int i = 0; i < 3; i++)
      prog_arith(16'($urandom), 16'($urandom), 16'($urandom));
    prog_skip(16'h7FFF, 16'h0001, 2'b00);
    prog_skip(16'hFFFF, 16'h0001, 2'b01);
    prog_skip(16'h0005, 16'h0000, 2'b10);
    prog_skip(16'h8000, 16'h0000, 2'b10);
    prog_skip(16'h0100, 16'h0000, 2'b11);
    for (int i = 0; i < 6; i++)
      prog_skip(16'($urandom), 16'($urandom), 2'($urandom_range(0, 3)));
    prog_io(8'hAB, 8'h3C);
    for (int i = 0; i < 2; i++)
      prog_io(8'($urandom), 8'($urandom));
    finish_run();
  end
endmodule